// File: doc/BRIEF.md
# Four-Port Memory Bank Front End

This block sits in front of one 16K-word storage bank that hangs on an 18-bit word-address bus. Four requesters share the bank: typically one processor port and several channel ports, or several processor ports in a multiprocessor build. Each port presents its own request, address, read/write select and write data, and gets back its own acknowledge. Read data is returned on one shared bus, next to a per-port parity error flag.

Each port has a private configuration: an enable, a 4-bit region select, a flag that turns off the lower half of the bank, a flag that turns off the upper half, and an interleave mode. Every port decodes its address on its own. Among the ports that hit, a fixed-priority arbiter grants the lowest-numbered one. The block then drives the storage interface for a fixed number of cycles and returns a one-cycle acknowledge. Parity is generated on writes and checked on reads.

Bus bit numbering runs from 18 (most significant) to 35 (least significant). Bus bit n sits on `p_addr[35-n]`. The controller has three states. `ST_IDLE` goes to `ST_ACCESS` when any port hits. `ST_ACCESS` stays put while its cycle counter runs, then goes to `ST_FINISH` on the last cycle. `ST_FINISH` always returns to `ST_IDLE`.

Top module: `quad_bank_front`

## Requirements
- R1: While reset is held and right after it is released, `p_ack`, `p_perr`, `mem_en` and `mem_we` are all 0.
- R2: In normal mode, a port hits when `p_addr[17:14]` equals its `cfg_base`. The internal word address driven on `mem_addr` is then `p_addr[13:0]`.
- R3: In interleave mode, the compared value is `{p_addr[17:15], p_addr[0]}`. The internal address is `{p_addr[13:1], p_addr[14]}`, so bus bit 21 becomes the lowest internal bit. An address whose compared value differs from `cfg_base` gets no access and no acknowledge.
- R4: A port whose `cfg_en` bit is 0 never starts an access and never receives an acknowledge.
- R5: With `cfg_lo_off` set, an internal address whose bit 13 is 0 is a non-match. With `cfg_hi_off` set, an internal address whose bit 13 is 1 is a non-match. Addresses in the other half are still served.
- R6: When several ports hit in the same cycle, the lowest-numbered port is served first. Only one access runs at a time, and at most one `p_ack` bit is set.
- R7: An access holds `mem_en` high for exactly `ACC_CYC` cycles with a stable `mem_addr` and `mem_we`. The granted port then gets a `p_ack` pulse one cycle wide, in the cycle after `mem_en` falls.
- R8: On a write, `mem_wdata[35:0]` equals the port's write data and `mem_wdata[36]` is the XOR of those 36 bits (even parity).
- R9: On a read, `p_rdata` carries `mem_rdata[35:0]` during the acknowledge. If the XOR of all 37 bits of `mem_rdata` is 1, the granted port's `p_perr` bit is set together with its acknowledge, which is still given.
- R10: Configuration is used only in `ST_IDLE`. Changing a port's enable or region while its access is in progress does not change that access's address or stop its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 4 | Per-port enable |
| cfg_base | input | 4x4 | Per-port region select |
| cfg_lo_off | input | 4 | Per-port lower-half disable |
| cfg_hi_off | input | 4 | Per-port upper-half disable |
| cfg_ilv | input | 4 | Per-port interleave mode |
| p_req | input | 4 | Per-port request, held until acknowledge |
| p_addr | input | 4x18 | Per-port bus word address |
| p_wr | input | 4 | Per-port write select (1 = write) |
| p_wdata | input | 4x36 | Per-port write data |
| p_ack | output | 4 | One-cycle acknowledge to the served port |
| p_rdata | output | 36 | Read data, valid with acknowledge |
| p_perr | output | 4 | Read parity error, valid with acknowledge |
| mem_en | output | 1 | Storage access strobe |
| mem_we | output | 1 | Storage write enable |
| mem_addr | output | 14 | Internal word address |
| mem_wdata | output | 37 | Write data with parity in bit 36 |
| mem_rdata | input | 37 | Registered read data from storage |

## Verification
Two things can land in the same cycle. The first is arbitration among several ports that hit together: the bench raises requests on two enabled ports at the same edge and checks that the acknowledges come in priority order, one access apart. The second is a configuration change landing in the middle of an access: the bench turns off and re-bases the active port while `mem_en` is high. It then judges that the address already latched is kept and the acknowledge still arrives. Seeded random accesses with random per-port configuration are compared against bench functions that compute the hit decision, the internal address and the even parity.

// File: rtl/qbf_pkg.sv
package qbf_pkg;
    // Bus word address: bus bit n sits on index (35 - n)
    localparam int BUS_AW  = 18;
    localparam int IDX_AW  = 14;
    localparam int TAG_W   = BUS_AW - IDX_AW;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FINISH = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/qbf_port_decode.sv
module qbf_port_decode
    import qbf_pkg::*;
(
    input  logic              req,
    input  logic              en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [TAG_W-1:0]  base,
    input  logic              lo_off,
    input  logic              hi_off,
    input  logic              ilv,
    output logic              hit,
    output logic [IDX_AW-1:0] iaddr
);
    logic [TAG_W-1:0] tag;
    logic             half_ok;

    always_comb begin
        if (ilv) begin
            // lowest bus bit joins the region compare; bus bit 21 drops to the bottom
            tag   = {addr[BUS_AW-1:IDX_AW+1], addr[0]};
            iaddr = {addr[IDX_AW-1:1], addr[IDX_AW]};
        end else begin
            tag   = addr[BUS_AW-1:IDX_AW];
            iaddr = addr[IDX_AW-1:0];
        end
        half_ok = iaddr[IDX_AW-1] ? !hi_off : !lo_off;
        hit     = req && en && (tag == base) && half_ok;
    end
endmodule

// File: rtl/qbf_prio_arb.sv
module qbf_prio_arb #(
    parameter int NPORT = 4,
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [NPORT-1:0] hit,
    output logic             any,
    output logic [PW-1:0]    idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = PW'(i);
            end
        end
    end
endmodule

// File: rtl/quad_bank_front.sv
module quad_bank_front
    import qbf_pkg::*;
#(
    parameter int NPORT   = 4,
    parameter int DW      = 36,
    parameter int ACC_CYC = 4,
    localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int CW     = $clog2(ACC_CYC + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORT-1:0]              cfg_en,
    input  logic [NPORT-1:0][TAG_W-1:0]   cfg_base,
    input  logic [NPORT-1:0]              cfg_lo_off,
    input  logic [NPORT-1:0]              cfg_hi_off,
    input  logic [NPORT-1:0]              cfg_ilv,
    input  logic [NPORT-1:0]              p_req,
    input  logic [NPORT-1:0][BUS_AW-1:0]  p_addr,
    input  logic [NPORT-1:0]              p_wr,
    input  logic [NPORT-1:0][DW-1:0]      p_wdata,
    output logic [NPORT-1:0]              p_ack,
    output logic [DW-1:0]                 p_rdata,
    output logic [NPORT-1:0]              p_perr,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [IDX_AW-1:0]             mem_addr,
    output logic [DW:0]                   mem_wdata,
    input  logic [DW:0]                   mem_rdata
);
    logic [NPORT-1:0]             hit_v;
    logic [NPORT-1:0][IDX_AW-1:0] iaddr_v;
    logic                         any_hit;
    logic [PW-1:0]                win_idx;

    ctl_state_t        state_q;
    logic [CW-1:0]     cnt_q;
    logic [PW-1:0]     sel_q;
    logic              wr_q;
    logic [IDX_AW-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rdata_q;
    logic              perr_q;

    // Decoders are only consulted in ST_IDLE, so config is effectively sampled only there
    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        qbf_port_decode u_dec (
            .req    (p_req[g]),
            .en     (cfg_en[g]),
            .addr   (p_addr[g]),
            .base   (cfg_base[g]),
            .lo_off (cfg_lo_off[g]),
            .hi_off (cfg_hi_off[g]),
            .ilv    (cfg_ilv[g]),
            .hit    (hit_v[g]),
            .iaddr  (iaddr_v[g])
        );
    end

    qbf_prio_arb #(.NPORT(NPORT)) u_arb (
        .hit (hit_v),
        .any (any_hit),
        .idx (win_idx)
    );

    // State register and access datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            perr_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_hit) begin
                        state_q <= ST_ACCESS;
                        cnt_q   <= '0;
                        sel_q   <= win_idx;
                        wr_q    <= p_wr[win_idx];
                        addr_q  <= iaddr_v[win_idx];
                        wdata_q <= p_wdata[win_idx];
                    end
                end
                ST_ACCESS: begin
                    if (cnt_q == CW'(ACC_CYC - 1)) begin
                        state_q <= ST_FINISH;
                        rdata_q <= mem_rdata[DW-1:0];
                        perr_q  <= (^mem_rdata) && !wr_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FINISH: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_en          = (state_q == ST_ACCESS);
        mem_we          = mem_en && wr_q;
        mem_addr        = addr_q;
        mem_wdata       = {^wdata_q, wdata_q};
        p_ack           = '0;
        p_ack[sel_q]    = (state_q == ST_FINISH);
        p_rdata         = rdata_q;
        p_perr          = p_ack & {NPORT{perr_q}};
    end

    assert_ack_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_ack));

    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|p_ack) |=> (p_ack == '0));

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && $past(mem_en)) |-> ($stable(mem_addr) && $stable(mem_we)));

    assert_ack_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|p_ack) |-> ($past(mem_en) && !mem_en));

    assert_perr_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|p_perr) |-> ((p_perr & p_ack) == p_perr));
endmodule

// File: tb/quad_bank_front_tb.sv
`timescale 1ns/1ps
module quad_bank_front_tb;
    localparam int NP  = 4;
    localparam int DW  = 36;
    localparam int ACC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [NP-1:0]        cfg_en = '0;
    logic [NP-1:0][3:0]   cfg_base = '0;
    logic [NP-1:0]        cfg_lo_off = '0;
    logic [NP-1:0]        cfg_hi_off = '0;
    logic [NP-1:0]        cfg_ilv = '0;
    logic [NP-1:0]        p_req = '0;
    logic [NP-1:0][17:0]  p_addr = '0;
    logic [NP-1:0]        p_wr = '0;
    logic [NP-1:0][DW-1:0] p_wdata = '0;
    logic [NP-1:0]        p_ack;
    logic [DW-1:0]        p_rdata;
    logic [NP-1:0]        p_perr;
    logic                 mem_en;
    logic                 mem_we;
    logic [13:0]          mem_addr;
    logic [DW:0]          mem_wdata;
    logic [DW:0]          mem_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    logic [DW:0] store [int];
    logic [DW-1:0] shadow [int];

    quad_bank_front #(.NPORT(NP), .DW(DW), .ACC_CYC(ACC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_lo_off(cfg_lo_off),
        .cfg_hi_off(cfg_hi_off), .cfg_ilv(cfg_ilv),
        .p_req(p_req), .p_addr(p_addr), .p_wr(p_wr), .p_wdata(p_wdata),
        .p_ack(p_ack), .p_rdata(p_rdata), .p_perr(p_perr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Storage model: registered read
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) store[int'(mem_addr)] = mem_wdata;
            mem_rdata <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : '0;
        end
    end

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [13:0] f_iaddr(input logic [17:0] a, input logic il);
        return il ? {a[13:1], a[14]} : a[13:0];
    endfunction

    function automatic logic [3:0] f_tag(input logic [17:0] a, input logic il);
        return il ? {a[17:15], a[0]} : a[17:14];
    endfunction

    function automatic logic f_hit(input logic en, input logic [3:0] base, input logic lo,
                                   input logic hi, input logic il, input logic [17:0] a);
        logic [13:0] ia;
        ia = f_iaddr(a, il);
        if (!en || f_tag(a, il) != base) return 1'b0;
        if (ia[13] && hi) return 1'b0;
        if (!ia[13] && lo) return 1'b0;
        return 1'b1;
    endfunction

    task automatic set_cfg(input int p, input logic en, input logic [3:0] base,
                           input logic lo, input logic hi, input logic il);
        cfg_en[p] = en; cfg_base[p] = base; cfg_lo_off[p] = lo;
        cfg_hi_off[p] = hi; cfg_ilv[p] = il;
    endtask

    task automatic do_access(input int p, input logic [17:0] a, input logic w, input logic [DW-1:0] d,
                             output logic acked, output logic [NP-1:0] ackv, output int nen,
                             output logic [13:0] ma, output logic mwe, output logic [DW:0] mwd,
                             output logic [DW-1:0] rd, output logic [NP-1:0] pe);
        acked = 1'b0; ackv = '0; nen = 0; ma = '0; mwe = 1'b0; mwd = '0; rd = '0; pe = '0;
        @(negedge clk);
        p_addr[p] = a; p_wr[p] = w; p_wdata[p] = d; p_req[p] = 1'b1;
        for (int k = 0; k < ACC + 8; k++) begin
            @(negedge clk);
            if (mem_en) begin
                if (nen == 0) begin ma = mem_addr; mwe = mem_we; mwd = mem_wdata; end
                nen++;
            end
            if (p_ack != '0) begin
                acked = 1'b1; ackv = p_ack; rd = p_rdata; pe = p_perr;
                break;
            end
        end
        p_req[p] = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        logic acked;
        logic [NP-1:0] ackv, pe;
        int nen;
        logic [13:0] ma;
        logic mwe;
        logic [DW:0] mwd;
        logic [DW-1:0] rd;
        logic [17:0] a;
        logic [DW-1:0] d;
        void'($urandom(32'd2024));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "ack in reset", 64'(p_ack), 0);
        chk("R1", "mem_en in reset", 64'(mem_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ack after reset", 64'(p_ack), 0);
        chk("R1", "perr after reset", 64'(p_perr), 0);
        chk("R1", "mem_en/we after reset", 64'({mem_en, mem_we}), 0);

        // R2, R7, R8: normal-mode write then read on port 0
        set_cfg(0, 1, 4'd3, 0, 0, 0);
        a = {4'd3, 14'h0123};
        d = 36'h9_A5A5_0F0F;
        do_access(0, a, 1'b1, d, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R2", "write acked", 64'(ackv), 64'h1);
        chk("R2", "internal addr", 64'(ma), 64'h0123);
        chk("R7", "access length", 64'(nen), 64'(ACC));
        chk("R8", "write data with parity", 64'(mwd), 64'({^d, d}));
        chk("R8", "write enable", 64'(mwe), 1);
        shadow[int'(14'h0123)] = d;
        do_access(0, a, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R9", "read data", 64'(rd), 64'(d));
        chk("R9", "no parity error", 64'(pe), 0);

        // R3: interleave hit and miss on port 1
        set_cfg(0, 0, 0, 0, 0, 0);
        set_cfg(1, 1, 4'b0101, 0, 0, 1);
        a = 18'b010_1_00_1100_1010_0111;
        d = 36'h1_2345_6789;
        do_access(1, a, 1'b1, d, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R3", "interleave ack", 64'(ackv), 64'h2);
        chk("R3", "interleave internal addr", 64'(ma), 64'(f_iaddr(a, 1'b1)));
        shadow[int'(f_iaddr(a, 1'b1))] = d;
        a[0] = 1'b0;
        do_access(1, a, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R3", "interleave miss no ack", 64'(acked), 0);
        chk("R3", "interleave miss no access", 64'(nen), 0);

        // R4: disabled port with matching region
        set_cfg(1, 0, 0, 0, 0, 0);
        set_cfg(2, 0, 4'd6, 0, 0, 0);
        do_access(2, {4'd6, 14'h0040}, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R4", "disabled port ack", 64'(acked), 0);
        chk("R4", "disabled port access", 64'(nen), 0);

        // R5: half disables on port 3
        set_cfg(2, 0, 0, 0, 0, 0);
        set_cfg(3, 1, 4'd9, 1, 0, 0);
        do_access(3, {4'd9, 14'h0200}, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R5", "low half off rejects", 64'(acked), 0);
        do_access(3, {4'd9, 14'h2200}, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R5", "low half off upper served", 64'(ackv), 64'h8);
        set_cfg(3, 1, 4'd9, 0, 1, 0);
        do_access(3, {4'd9, 14'h2200}, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R5", "high half off rejects", 64'(acked), 0);
        do_access(3, {4'd9, 14'h0200}, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R5", "high half off lower served", 64'(ackv), 64'h8);
        set_cfg(3, 0, 0, 0, 0, 0);

        // R6: simultaneous requests on ports 0 and 2
        set_cfg(0, 1, 4'd0, 0, 0, 0);
        set_cfg(2, 1, 4'd0, 0, 0, 0);
        @(negedge clk);
        p_addr[0] = 18'h00010; p_wr[0] = 1'b0;
        p_addr[2] = 18'h00020; p_wr[2] = 1'b0;
        p_req[0] = 1'b1; p_req[2] = 1'b1;
        ackv = '0;
        for (int k = 0; k < ACC + 8 && ackv == '0; k++) begin
            @(negedge clk);
            ackv = p_ack;
        end
        chk("R6", "first grant to port 0", 64'(ackv), 64'h1);
        p_req[0] = 1'b0;
        ackv = '0;
        for (int k = 0; k < ACC + 8 && ackv == '0; k++) begin
            @(negedge clk);
            ackv = p_ack;
        end
        chk("R6", "second grant to port 2", 64'(ackv), 64'h4);
        p_req[2] = 1'b0;
        set_cfg(2, 0, 0, 0, 0, 0);

        // R9: parity error on read still acknowledged
        a = {4'd0, 14'h0777};
        d = 36'h0_FFFF_0001;
        do_access(0, a, 1'b1, d, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        store[int'(14'h0777)] = store[int'(14'h0777)] ^ 37'h20;
        do_access(0, a, 1'b0, '0, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        chk("R9", "ack despite parity error", 64'(ackv), 64'h1);
        chk("R9", "parity error flag", 64'(pe), 64'h1);
        chk("R9", "corrupted data returned", 64'(rd), 64'(d ^ 36'h20));
        do_access(0, a, 1'b1, d, acked, ackv, nen, ma, mwe, mwd, rd, pe);
        shadow[int'(14'h0777)] = d;

        // R10: config change during an access
        set_cfg(0, 0, 0, 0, 0, 0);
        set_cfg(1, 1, 4'd2, 0, 0, 0);
        @(negedge clk);
        p_addr[1] = {4'd2, 14'h1357}; p_wr[1] = 1'b0; p_req[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cfg_en[1] = 1'b0; cfg_base[1] = 4'd7;
        ackv = '0; ma = mem_addr;
        for (int k = 0; k < ACC + 8 && ackv == '0; k++) begin
            @(negedge clk);
            ackv = p_ack;
        end
        chk("R10", "ack survives config change", 64'(ackv), 64'h2);
        chk("R10", "address kept", 64'(ma), 64'h1357);
        p_req[1] = 1'b0;
        set_cfg(1, 0, 0, 0, 0, 0);

        // Random accesses, one port configured at a time
        for (int it = 0; it < 300; it++) begin
            int p;
            logic en, lo, hi, il, w, eh;
            logic [3:0] base;
            logic [13:0] ei;
            p = int'($urandom % NP);
            en = ($urandom % 10) != 0;
            base = 4'($urandom);
            lo = ($urandom % 4) == 0;
            hi = ($urandom % 4) == 0;
            il = 1'($urandom);
            w = 1'($urandom);
            a = 18'($urandom);
            d = {4'($urandom), 32'($urandom)};
            if ($urandom % 2) begin
                if (il) begin a[17:15] = base[3:1]; a[0] = base[0]; end
                else a[17:14] = base;
            end
            set_cfg(p, en, base, lo, hi, il);
            eh = f_hit(en, base, lo, hi, il, a);
            ei = f_iaddr(a, il);
            do_access(p, a, w, d, acked, ackv, nen, ma, mwe, mwd, rd, pe);
            chk("R4", "random hit decision", 64'(acked), 64'(eh));
            if (eh) begin
                chk("R6", "random ack port", 64'(ackv), 64'(1 << p));
                chk(il ? "R3" : "R2", "random internal addr", 64'(ma), 64'(ei));
                chk("R7", "random access length", 64'(nen), 64'(ACC));
                if (w) begin
                    chk("R8", "random write parity", 64'(mwd), 64'({^d, d}));
                    shadow[int'(ei)] = d;
                end else begin
                    chk("R9", "random read data", 64'(rd),
                        64'(shadow.exists(int'(ei)) ? shadow[int'(ei)] : '0));
                    chk("R9", "random read perr", 64'(pe), 0);
                end
            end
            set_cfg(p, 0, 0, 0, 0, 0);
        end

        summary();
        $finish;
    end
endmodule